// File: doc/BRIEF.md
# One-Shot Event Timer with Free-Running Timestamp

This peripheral pairs a single-shot countdown with a running time base. A 32-bit event counter is loaded with a number of ticks. Once software enables it, the counter moves down by one on every tick strobe. When it reaches zero it raises a sticky expiry flag. That flag drives a level interrupt and also switches the countdown off. Next to it, a 32-bit timestamp counter advances on the same tick strobe without stopping, so software can read it as a clock source.

Software uses a small register window. Word registers hold the countdown value and the timestamp. A control/status byte holds the enable bit, two mode bits that are kept but not acted on, and the expiry flag, which is cleared by writing one to it. To arm an event, software first writes the byte with only the flag bit set, which stops the countdown and clears the flag. It then writes the tick count, then writes the byte with both the flag bit and the enable bit set. The tick strobe comes from a prescaler outside the block (nominally 1 MHz). Software is expected to load counts from 0xF upward.

Top module: `event_timer`

## Requirements
- R1: A synchronous reset leaves the countdown, the timestamp and the control byte at zero, with the interrupt deasserted.
- R2: A write to offset 0x00 loads the countdown with the written word. The loaded value reads back at offset 0x00 on the next cycle.
- R3: With control bit 0 (enable) set, each cycle with tickEn high lowers the countdown by one. Without a tick, or with enable clear, the countdown holds.
- R4: A tick taken while enabled with the countdown at 1 brings it to 0. In the same edge it sets control bit 7 (expiry flag) and clears the enable bit.
- R5: The irq output follows the expiry flag. It stays high until software clears the flag.
- R6: A control write (offset 0x14, low data byte) with bit 7 set clears the flag. A control write with bit 7 clear leaves the flag as it was. Bit 0 of each control write sets the enable bit.
- R7: When an expiry and a clearing control write land in the same cycle, the flag ends up set.
- R8: Control bits 1 and 2 are stored and read back. They do not change counting, and expiry still clears enable while keeping them.
- R9: The timestamp at offset 0x08 rises by one on each tickEn cycle, whatever the enable bit holds, modulo 2^32. Writes to offset 0x08 have no effect.
- R10: An enabled countdown sitting at 0 stays at 0 on ticks and raises no expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | One-cycle tick strobe from the prescaler |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 5 | Byte offset of the register accessed |
| busWdata | input | 32 | Write data; control writes use bits 7:0 |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irq | output | 1 | Level interrupt, high while the expiry flag is set |

## Verification
The countdown is tried in several ways: with ticks while disabled, with ticks while enabled, and with idle gaps that have no tick. This separates the tick qualifier from the enable qualifier. It is then run through a full arm-and-expire sequence, ticked further after expiry, and armed at zero. These cases show the 1-to-0 expiry edge, the automatic disable, and the no-wrap hold at zero. Control writes with and without bit 7, and one that coincides with an expiry, separate the clear from the set priority. Writes carrying the mode bits and writes to the timestamp show that these leave the counters alone.

// File: rtl/event_timer_pkg.sv
package event_timer_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAMP = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h14;

  localparam int BIT_ENABLE = 0;
  localparam int BIT_MODE_A = 1;
  localparam int BIT_MODE_B = 2;
  localparam int BIT_FLAG   = 7;

  typedef struct packed {
    logic loadCount;
    logic stepCount;
    logic stepStamp;
  } dpStrobe_t;
endpackage

// File: rtl/event_timer_datapath.sv
module event_timer_datapath
  import event_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] countQ,
  output logic [TS_W-1:0]  stampQ,
  output logic             countIsOne
);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [TS_W-1:0]  TS_ONE   = TS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      countQ <= '0;
    end else if (strobe.loadCount) begin
      countQ <= loadVal;
    end else if (strobe.stepCount && countQ != CNT_ZERO) begin
      countQ <= countQ - CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stampQ <= '0;
    end else if (strobe.stepStamp) begin
      stampQ <= stampQ + TS_ONE;
    end
  end

  assign countIsOne = (countQ == CNT_ONE);
endmodule

// File: rtl/event_timer_control.sv
module event_timer_control
  import event_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        wrByte,
  input  logic              countIsOne,
  output dpStrobe_t         strobe,
  output logic [7:0]        ctrlByte,
  output logic              irq
);
  logic enQ, modeAQ, modeBQ, flagQ;
  logic ctrlWr, countWr, fire;

  always_comb begin
    ctrlWr  = busWrEn && (busAddr == OFS_CTRL);
    countWr = busWrEn && (busAddr == OFS_COUNT);
    fire    = enQ && tickEn && countIsOne && !countWr;
    strobe.loadCount = countWr;
    strobe.stepCount = enQ && tickEn;
    strobe.stepStamp = tickEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ    <= 1'b0;
      modeAQ <= 1'b0;
      modeBQ <= 1'b0;
    end else if (ctrlWr) begin
      enQ    <= wrByte[BIT_ENABLE];
      modeAQ <= wrByte[BIT_MODE_A];
      modeBQ <= wrByte[BIT_MODE_B];
    end else if (fire) begin
      enQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ <= 1'b0;
    end else if (fire) begin
      flagQ <= 1'b1;
    end else if (ctrlWr && wrByte[BIT_FLAG]) begin
      flagQ <= 1'b0;
    end
  end

  always_comb begin
    ctrlByte = '0;
    ctrlByte[BIT_ENABLE] = enQ;
    ctrlByte[BIT_MODE_A] = modeAQ;
    ctrlByte[BIT_MODE_B] = modeBQ;
    ctrlByte[BIT_FLAG]   = flagQ;
  end

  assign irq = flagQ;
endmodule

// File: rtl/event_timer.sv
module event_timer
  import event_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              busWrEn,
  input  logic [4:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] stampQ;
  logic              countIsOne;
  logic [7:0]        ctrlByte;
  logic              enBit;

  event_timer_control u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tickEn     (tickEn),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .wrByte     (busWdata[7:0]),
    .countIsOne (countIsOne),
    .strobe     (strobe),
    .ctrlByte   (ctrlByte),
    .irq        (irq)
  );

  event_timer_datapath #(.CNT_W(DATA_W), .TS_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .loadVal    (busWdata),
    .countQ     (countQ),
    .stampQ     (stampQ),
    .countIsOne (countIsOne)
  );

  assign enBit = ctrlByte[BIT_ENABLE];

  always_comb begin
    unique case (busAddr)
      OFS_COUNT: busRdata = countQ;
      OFS_STAMP: busRdata = stampQ;
      OFS_CTRL:  busRdata = DATA_W'(ctrlByte);
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/event_timer_checker.sv
module event_timer_checker
  import event_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tickEn,
  input logic              busWrEn,
  input logic [4:0]        busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              irq,
  input logic [DATA_W-1:0] countQ,
  input logic [DATA_W-1:0] stampQ,
  input logic              enBit
);
  logic anyWr, ctrlWr, clrWr, expiring;
  assign anyWr    = busWrEn && (busAddr == OFS_COUNT || busAddr == OFS_CTRL);
  assign ctrlWr   = busWrEn && busAddr == OFS_CTRL;
  assign clrWr    = ctrlWr && busWdata[BIT_FLAG];
  assign expiring = enBit && tickEn && countQ == DATA_W'(1);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (enBit && tickEn && countQ > DATA_W'(1) && !anyWr) |=> countQ == $past(countQ) - DATA_W'(1));

  assert_expiry_R4: assert property (@(posedge clk) disable iff (rst)
    (expiring && !anyWr) |=> (irq && countQ == '0 && !enBit));

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (irq && !clrWr) |=> irq);

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clrWr && !expiring) |=> !irq);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (clrWr && expiring && busAddr == OFS_CTRL) |=> irq);

  assert_stamp_step_R9: assert property (@(posedge clk) disable iff (rst)
    tickEn |=> stampQ == $past(stampQ) + DATA_W'(1));

  assert_zero_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (countQ == '0 && !anyWr && !irq) |=> (countQ == '0 && !irq));
endmodule

bind event_timer event_timer_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tickEn   (tickEn),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .irq      (irq),
  .countQ   (countQ),
  .stampQ   (stampQ),
  .enBit    (enBit)
);

// File: tb/event_timer_bench.sv
module event_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tickEn = 1'b0;
  logic        busWrEn = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int stampExp = 0;
  logic rdStrobe = 1'b0;
  bit finished = 0;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t expQ[$];

  event_timer u_event_timer (
    .clk(clk), .rst(rst), .tickEn(tickEn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  always #10 clk = ~clk;

  // monitor: pops expected items and compares away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rdStrobe && expQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = expQ.pop_front();
      act = it.isIrq ? {31'b0, irq} : busRdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc(input logic we, input logic [4:0] a, input logic [31:0] d,
                     input logic tk, input logic rd);
    @(negedge clk);
    busWrEn = we; busAddr = a; busWdata = d; tickEn = tk; rdStrobe = rd;
    if (tk) stampExp++;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 5'h00, 32'h0, 1'b1, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 5'h00, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic rdChk(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.isIrq = 0; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    cyc(1'b0, a, 32'h0, 1'b0, 1'b1);
  endtask

  task automatic irqChk(input logic e, input string tag);
    item_t it;
    it.isIrq = 1; it.exp = {31'b0, e}; it.tag = tag;
    expQ.push_back(it);
    cyc(1'b0, 5'h00, 32'h0, 1'b0, 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rdChk(5'h00, 32'h0, "R1 count");
    rdChk(5'h08, 32'h0, "R1 stamp");
    rdChk(5'h14, 32'h0, "R1 ctrl");
    irqChk(1'b0, "R1 irq");
    // R2 load
    wr(5'h00, 32'd20);
    rdChk(5'h00, 32'd20, "R2 load");
    // R3 disabled hold, R9 stamp runs regardless
    ticks(5);
    rdChk(5'h00, 32'd20, "R3 disabled hold");
    rdChk(5'h08, stampExp, "R9 stamp while disabled");
    // R3 enabled countdown
    wr(5'h14, 32'h81);
    rdChk(5'h14, 32'h01, "R6 enable set");
    ticks(5);
    rdChk(5'h00, 32'd15, "R3 countdown");
    idle(3);
    rdChk(5'h00, 32'd15, "R3 no tick hold");
    wr(5'h14, 32'h80);
    ticks(3);
    rdChk(5'h00, 32'd15, "R3 stopped hold");
    rdChk(5'h08, stampExp, "R9 stamp count");
    // R4/R5 arm and expire
    wr(5'h14, 32'h80);
    wr(5'h00, 32'd3);
    wr(5'h14, 32'h81);
    ticks(2);
    rdChk(5'h00, 32'd1, "R3 down to one");
    irqChk(1'b0, "R5 irq low before expiry");
    ticks(1);
    rdChk(5'h00, 32'd0, "R4 count zero");
    rdChk(5'h14, 32'h80, "R4 flag set enable cleared");
    irqChk(1'b1, "R5 irq high");
    ticks(4);
    rdChk(5'h00, 32'd0, "R10 no wrap after expiry");
    idle(5);
    irqChk(1'b1, "R5 irq sticky");
    // R6 clear semantics
    wr(5'h14, 32'h00);
    rdChk(5'h14, 32'h80, "R6 zero bit7 keeps flag");
    wr(5'h14, 32'h80);
    rdChk(5'h14, 32'h00, "R6 clear flag");
    irqChk(1'b0, "R6 irq cleared");
    // R10 armed at zero
    wr(5'h00, 32'd0);
    wr(5'h14, 32'h01);
    ticks(3);
    rdChk(5'h00, 32'd0, "R10 zero hold");
    rdChk(5'h14, 32'h01, "R10 no expiry");
    irqChk(1'b0, "R10 irq low");
    // R8 mode bits stored, no effect
    wr(5'h14, 32'h80);
    wr(5'h00, 32'd2);
    wr(5'h14, 32'h87);
    rdChk(5'h14, 32'h07, "R8 mode readback");
    ticks(1);
    rdChk(5'h00, 32'd1, "R8 normal step");
    ticks(1);
    rdChk(5'h14, 32'h86, "R8 one-shot stop keeps mode");
    ticks(2);
    rdChk(5'h00, 32'd0, "R8 stays stopped");
    wr(5'h14, 32'h80);
    // R7 clear coinciding with expiry
    wr(5'h00, 32'd1);
    wr(5'h14, 32'h01);
    cyc(1'b1, 5'h14, 32'h81, 1'b1, 1'b0);
    rdChk(5'h14, 32'h81, "R7 set wins");
    irqChk(1'b1, "R7 irq high");
    wr(5'h14, 32'h80);
    irqChk(1'b0, "R6 final clear");
    // R9 writes to stamp ignored
    rdChk(5'h08, stampExp, "R9 stamp before write");
    wr(5'h08, 32'hDEAD_BEEF);
    rdChk(5'h08, stampExp, "R9 stamp write ignored");
    ticks(7);
    rdChk(5'h08, stampExp, "R9 stamp after ticks");
    idle(2);
    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule